// File: doc/BRIEF.md
# Vectored Interrupt and Hold-Wake Controller

This block gathers eight event sources of a small microcontroller into a flag register. Each flag has an enable in an interrupt mask. Among the events that are both pending and enabled, a fixed priority picks one. The block then raises an interrupt request. When the core acknowledges, the block latches the vector address of the chosen source and clears that source's flag alone. After each acceptance every interrupt stays blocked until software rewrites the mask or issues a global enable. A global disable command blocks them as well.

A second mask selects which events may end the low-power hold state. When an event is pending and its bit in that mask is set, the block raises a matching wake-cause flag. While any wake-cause flag is set, the hold-release output stays high.

Seven of the eight sources arrive as one-cycle pulses from on-chip logic. The external pin is asynchronous: it passes through a two-flop synchronizer, and its falling edge is detected after that.

Top module: `irq_wake_ctrl`

## Requirements
- R1: Flag bit positions are: 0 divider overflow, 1 timer 0 underflow, 2 port change, 4 external pin falling edge, 5 serial receive done, 6 serial transmit done, 7 timer 1 underflow. A one-cycle pulse on `src_pulse[i]` sets flag i at the next clock edge. Bit 3 is reserved and always reads 0. `src_pulse[3]` and `src_pulse[4]` have no effect.
- R2: `irq_req` is high exactly when the global enable is set and some flag bit is set together with its `ien_wdata`-written mask bit. An acknowledge while `irq_req` is low changes neither the flags nor `irq_vector`.
- R3: Bit 0 has the highest priority and bit 7 the lowest. Only enabled, pending bits take part. On an accepted acknowledge, `irq_vector` latches 4*(i+1) for the winning bit i: 004h, 008h, 00Ch, 014h, 018h, 01Ch and 020h.
- R4: An accepted acknowledge clears only the winning flag bit and leaves every other flag bit unchanged.
- R5: After an accepted acknowledge, `irq_req` stays low until `ien_we` or `gie_set` is pulsed. A `gie_clr` pulse also forces `irq_req` low.
- R6: `wake_flags[i]` is set whenever flag i and hold-release mask bit i are both set. `hold_release` is high while any wake-cause flag is set.
- R7: A wake-cause flag clears when its event flag is cleared. Clearing happens through `clr_we` with a 1 in that bit of `clr_wdata`. A wake-cause flag also clears when the hold-release mask is written with a 0 in that bit.
- R8: After reset the flags, the interrupt mask, the hold-release mask, the wake-cause flags, the global enable and `irq_vector` are all 0, so `irq_req` and `hold_release` are low.
- R9: A high-to-low change on `ext_pin` sets flag bit 4 on the third rising clock edge after the change. A low-to-high change sets nothing.
- R10: When a set pulse and a clear (write or acknowledge) hit the same flag bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 8 | One-cycle event pulses, bit positions as in R1 |
| ext_pin | input | 1 | Asynchronous external interrupt pin, idle high |
| ien_we | input | 1 | Write strobe for the interrupt enable mask |
| ien_wdata | input | 8 | New interrupt enable mask |
| hre_we | input | 1 | Write strobe for the hold-release enable mask |
| hre_wdata | input | 8 | New hold-release enable mask |
| clr_we | input | 1 | Write strobe for clearing event flags |
| clr_wdata | input | 8 | A 1 clears the matching event flag |
| gie_set | input | 1 | Global interrupt enable command |
| gie_clr | input | 1 | Global interrupt disable command |
| irq_ack | input | 1 | Interrupt acknowledge from the core |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | 11 | Vector address latched at the last accepted acknowledge |
| hold_release | output | 1 | Hold-mode release |
| evt_flags | output | 8 | Event flag register |
| wake_flags | output | 8 | Latched wake-cause flags |

## Verification
The assertions assume the following about the inputs:
- Every strobe and source pulse is synchronous to `clk`. Only `ext_pin` may change freely.
- `gie_set` and `gie_clr` never arrive in the same cycle.
- An acknowledge counts only while `irq_req` is high.

The bench drives every input on the falling clock edge and holds pulses and strobes for exactly one cycle. It moves `ext_pin` only through slow level changes, and it never raises the two global commands together.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
    localparam int NUM_SRC  = 8;
    localparam int VEC_W    = 11;
    localparam int EXT_BIT  = 4;
    localparam int RSV_BIT  = 3;
    localparam logic [NUM_SRC-1:0] RSV_MASK = NUM_SRC'(1) << RSV_BIT;
    localparam logic [NUM_SRC-1:0] EXT_MASK = NUM_SRC'(1) << EXT_BIT;

    typedef struct packed {
        logic [NUM_SRC-1:0] evt;
        logic [NUM_SRC-1:0] ien;
        logic [NUM_SRC-1:0] hre;
        logic [NUM_SRC-1:0] wake;
        logic               gie;
        logic [VEC_W-1:0]   vec;
    } ctl_state_t;
endpackage

// File: rtl/pin_fall_sync.sv
module pin_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], pin_async};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sync: '1, prev: 1'b1};
        else        s_q <= s_d;
    end

    assign fall = s_q.prev & ~s_q.sync[STAGES-1];

    // R9: a detected edge lasts one cycle only
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 8,
    parameter int VW = 11
) (
    input  logic [N-1:0]  pend,
    output logic [N-1:0]  grant,
    output logic [VW-1:0] vec,
    output logic          any
);
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = VW'((i + 1) * 4);
            end
        end
        any = |pend;
    end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import irq_wake_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               ext_pin,
    input  logic               ien_we,
    input  logic [NUM_SRC-1:0] ien_wdata,
    input  logic               hre_we,
    input  logic [NUM_SRC-1:0] hre_wdata,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_wdata,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               irq_ack,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector,
    output logic               hold_release,
    output logic [NUM_SRC-1:0] evt_flags,
    output logic [NUM_SRC-1:0] wake_flags
);
    ctl_state_t st_d, st_q;

    logic               ext_fall;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic [VEC_W-1:0]   pick_vec;
    logic               pick_any;
    logic               ack_taken;

    pin_fall_sync #(.STAGES(2)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(ext_pin),
        .fall     (ext_fall)
    );

    assign set_vec = (src_pulse & ~(RSV_MASK | EXT_MASK))
                   | (ext_fall ? EXT_MASK : '0);
    assign pend    = st_q.evt & st_q.ien & {NUM_SRC{st_q.gie}};

    irq_prio_pick #(.N(NUM_SRC), .VW(VEC_W)) u_pick (
        .pend (pend),
        .grant(grant),
        .vec  (pick_vec),
        .any  (pick_any)
    );

    assign irq_req   = pick_any;
    assign ack_taken = irq_ack & pick_any;

    always_comb begin
        logic [NUM_SRC-1:0] clr_mask;
        logic [NUM_SRC-1:0] ack_mask;
        st_d     = st_q;
        clr_mask = clr_we    ? clr_wdata : '0;
        ack_mask = ack_taken ? grant     : '0;
        st_d.evt = ((st_q.evt & ~clr_mask & ~ack_mask) | set_vec) & ~RSV_MASK;
        if (ien_we) st_d.ien = ien_wdata;
        if (hre_we) st_d.hre = hre_wdata & ~RSV_MASK;
        if (ack_taken)                 st_d.gie = 1'b0;
        else if (gie_clr)              st_d.gie = 1'b0;
        else if (gie_set || ien_we)    st_d.gie = 1'b1;
        if (ack_taken) st_d.vec = pick_vec;
        st_d.wake = st_d.evt & st_d.hre;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_vector   = st_q.vec;
    assign evt_flags    = st_q.evt;
    assign wake_flags   = st_q.wake;
    assign hold_release = |st_q.wake;

    // R1: reserved bit never set
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flags[RSV_BIT] == 1'b0);

    // R3: a request always names exactly one winner
    a_r3_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $onehot(grant));

    // R4: the winner is cleared unless re-set in the same cycle
    a_r4_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ack_taken |=> (evt_flags & $past(grant) & ~$past(set_vec)) == '0);

    // R4: no other flag moves on an acknowledge except through new pulses
    a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_taken && !clr_we) |=>
        ((evt_flags ^ $past(evt_flags)) & ~$past(grant) & ~$past(set_vec)) == '0);

    // R5: inhibited after acceptance
    a_r5_inhibit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_taken && !ien_we && !gie_set) |=> !irq_req);

    // R6: a wake cause always has its event pending
    a_r6_wake_has_event: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |-> ((wake_flags & ~evt_flags) == '0));
endmodule

// File: tb/irq_wake_ctrl_test.sv
module irq_wake_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_pulse = '0;
    logic        ext_pin = 1'b1;
    logic        ien_we = 1'b0, hre_we = 1'b0, clr_we = 1'b0;
    logic [7:0]  ien_wdata = '0, hre_wdata = '0, clr_wdata = '0;
    logic        gie_set = 1'b0, gie_clr = 1'b0, irq_ack = 1'b0;
    logic        irq_req, hold_release;
    logic [10:0] irq_vector;
    logic [7:0]  evt_flags, wake_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    irq_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .ext_pin(ext_pin),
        .ien_we(ien_we), .ien_wdata(ien_wdata), .hre_we(hre_we), .hre_wdata(hre_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector),
        .hold_release(hold_release), .evt_flags(evt_flags), .wake_flags(wake_flags)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<20000 cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // {pulse, clear mask, expected flags}
    localparam logic [23:0] TBL [8] = '{
        {8'h01, 8'h00, 8'h01},   // R1 divider bit
        {8'h08, 8'h00, 8'h01},   // R1 reserved pulse ignored
        {8'h10, 8'h00, 8'h01},   // R1 bit 4 pulse ignored
        {8'h82, 8'h00, 8'h83},   // R1 two sources at once
        {8'h00, 8'h01, 8'h82},   // R7 clear write
        {8'h20, 8'h20, 8'hA2},   // R10 set wins over clear
        {8'h00, 8'hFF, 8'h00},   // clear all
        {8'h64, 8'h00, 8'h64}    // R1 mixed
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] v);
        src_pulse = v; tick(); src_pulse = '0;
    endtask

    task automatic wr_ien(input logic [7:0] v);
        ien_we = 1'b1; ien_wdata = v; tick(); ien_we = 1'b0;
    endtask

    task automatic wr_hre(input logic [7:0] v);
        hre_we = 1'b1; hre_wdata = v; tick(); hre_we = 1'b0;
    endtask

    task automatic wr_clr(input logic [7:0] v);
        clr_we = 1'b1; clr_wdata = v; tick(); clr_we = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic gset();
        gie_set = 1'b1; tick(); gie_set = 1'b0;
    endtask

    task automatic gclr();
        gie_clr = 1'b1; tick(); gie_clr = 1'b0;
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R8 flags", evt_flags, 8'h00);
        chk("R8 wake", wake_flags, 8'h00);
        chk("R8 req", irq_req, 0);
        chk("R8 hold", hold_release, 0);
        chk("R8 vector", irq_vector, 0);

        for (int i = 0; i < 8; i++) begin
            src_pulse = TBL[i][23:16];
            clr_we    = (TBL[i][15:8] != 0);
            clr_wdata = TBL[i][15:8];
            tick();
            src_pulse = '0; clr_we = 1'b0;
            chk($sformatf("R1 table row %0d flags", i), evt_flags, TBL[i][7:0]);
            chk($sformatf("R2 table row %0d no req", i), irq_req, 0);
        end

        wr_clr(8'hFF);
        pulse(8'h83);
        chk("R2 masked no req", irq_req, 0);
        ack();
        chk("R2 ack ignored flags", evt_flags, 8'h83);
        chk("R2 ack ignored vector", irq_vector, 0);

        wr_ien(8'h02);
        chk("R2 req after enable", irq_req, 1);
        ack();
        chk("R3 enabled winner vector", irq_vector, 11'h008);
        chk("R4 only bit1 cleared", evt_flags, 8'h81);
        chk("R5 inhibited after ack", irq_req, 0);

        wr_ien(8'hFF);
        chk("R5 mask write re-enables", irq_req, 1);
        ack();
        chk("R3 divider vector", irq_vector, 11'h004);
        chk("R4 divider cleared", evt_flags, 8'h80);
        gset();
        chk("R5 global enable", irq_req, 1);
        ack();
        chk("R3 timer1 vector", irq_vector, 11'h020);
        chk("R4 empty", evt_flags, 8'h00);

        pulse(8'h40);
        chk("R5 still inhibited", irq_req, 0);
        gset();
        chk("R5 gie set", irq_req, 1);
        gclr();
        chk("R5 gie clr", irq_req, 0);
        wr_ien(8'hFF);
        chk("R5 mask rewrite", irq_req, 1);
        ack();
        chk("R3 serial out vector", irq_vector, 11'h01C);

        wr_ien(8'h00);
        wr_hre(8'h04);
        pulse(8'h04);
        chk("R6 wake set", wake_flags, 8'h04);
        chk("R6 hold release", hold_release, 1);
        pulse(8'h01);
        chk("R6 unmasked no wake", wake_flags, 8'h04);
        wr_clr(8'h04);
        chk("R7 clear event drops wake", wake_flags, 8'h00);
        chk("R7 hold drops", hold_release, 0);
        pulse(8'h04);
        chk("R6 wake again", wake_flags, 8'h04);
        wr_hre(8'h00);
        chk("R7 mask write drops wake", wake_flags, 8'h00);
        chk("R7 event kept", evt_flags, 8'h05);
        wr_clr(8'hFF);

        ext_pin = 1'b0;
        tick();
        tick();
        chk("R9 not yet after two edges", evt_flags[4], 0);
        tick();
        chk("R9 set on third edge", evt_flags[4], 1);
        tick();
        wr_clr(8'h10);
        ext_pin = 1'b1;
        repeat (5) tick();
        chk("R9 rising edge ignored", evt_flags, 8'h00);
        ext_pin = 1'b0;
        repeat (4) tick();
        wr_ien(8'hFF);
        chk("R9 pin request", irq_req, 1);
        ack();
        chk("R3 pin vector", irq_vector, 11'h014);
        chk("R4 pin cleared", evt_flags, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule